// File: doc/BRIEF.md
# Set-Associative Data Address Translation Buffer

This block turns 32-bit effective addresses into physical addresses for the data side of a processor, using 4096-byte pages. It holds a set-associative array of entries (sets by ways). Each entry has a match word and a translate word. The match word holds the virtual page number, a valid flag and a replacement hint bit. The translate word holds the physical page number, a cache-inhibit flag and four access permission flags.

Software fills and inspects entries through a small register port that addresses one word of one entry by way and set. Nothing walks page tables in hardware. On a miss the block flags the access and keeps the faulting address, and a software handler reloads the entry. The replacement hint bit shows the handler which way to overwrite.

The lookup path is combinational. Hit, miss, fault and the physical address all belong to the cycle in which the access is presented. The faulting address register and the hint bits update at the next clock edge.

Top module: `xlat_tlb`

## Requirements
- R1: On a hit, `lk_pa` equals the stored physical page number in bits 31:12 with `lk_addr[11:0]` passed through unchanged.
- R2: The set searched is `lk_addr[15:12]` (with 16 sets). An entry stored in any other set never produces a hit.
- R3: A hit requires the full 20-bit stored page number to equal `lk_addr[31:12]`. Flipping any single bit 12..31 of a hitting address gives a miss. `lk_hit` and `lk_miss` are never high together.
- R4: An entry whose valid flag is 0 never hits, even when its stored page number matches.
- R5: When translation is enabled, an access that finds no valid match drives `lk_miss` high in that cycle, and `fault_ea` holds that address from the next edge on. `fault_ea` keeps its value over hits and disabled accesses.
- R6: The translate word's bits are: bit 0 cache-inhibit, bit 1 supervisor read, bit 2 supervisor write, bit 3 user read, bit 4 user write. A hit whose access kind (`lk_user`, `lk_write`) lacks its permission bit raises `lk_fault`. `lk_ci` copies bit 0 on a hit.
- R7: The match word's bits are: bit 0 valid, bit 1 replacement hint, bits 31:12 page number. With 2 ways, a hit sets the hint of the way used to 1 and clears the other way's hint to 0, as seen in readback.
- R8: With `xlat_en` low, `lk_pa` equals `lk_addr`, and `lk_hit`, `lk_miss` and `lk_fault` stay low.
- R9: A write through the register port (`cfg_word` 0 selects the match word, 1 the translate word) takes effect for the next access. `cfg_rdata` returns the fields of the selected word, with the unused bits reading 0.
- R10: When several ways of a set match, the lowest-numbered way supplies the translation.
- R11: After reset every entry reads as all zero (invalid, hint 0), `fault_ea` is 0, and any enabled access misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| xlat_en | input | 1 | Translation enable |
| cfg_wr | input | 1 | Register port write strobe |
| cfg_word | input | 1 | 0 selects the match word, 1 the translate word |
| cfg_way | input | 1 | Way select |
| cfg_set | input | 4 | Set select |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Readback of the selected word |
| lk_valid | input | 1 | Access present |
| lk_addr | input | 32 | Effective address |
| lk_write | input | 1 | 1 for a store, 0 for a load |
| lk_user | input | 1 | 1 for user mode, 0 for supervisor |
| lk_pa | output | 32 | Physical address |
| lk_hit | output | 1 | Valid translation found |
| lk_miss | output | 1 | No valid translation found |
| lk_fault | output | 1 | Permission denied on a hit |
| lk_ci | output | 1 | Cache-inhibit flag of the hit entry |
| fault_ea | output | 32 | Last missing effective address |

## Verification
The hardest case to reach from the ports is two ways of one set holding the same page number. Normal refill never creates it. The bench writes the duplicate on purpose, checks that the lower way's physical page wins, then invalidates only that way to show the other way takes over. The replacement hints are internal state, so the bench reads them back through the register port after each hit to see the pair flip. The tag check walks a single flipped bit across all twenty page-number bits. A flip in the low four of those bits changes the set, and a flip above them keeps the set but breaks the tag compare.

// File: rtl/xlat_tlb.sv
module xlat_tlb #(
  parameter int AW     = 32,
  parameter int OFF_W  = 12,
  parameter int SETS   = 16,
  parameter int WAYS   = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 xlat_en,
  input  logic                 cfg_wr,
  input  logic                 cfg_word,
  input  logic [((WAYS>1)?$clog2(WAYS):1)-1:0] cfg_way,
  input  logic [$clog2(SETS)-1:0] cfg_set,
  input  logic [AW-1:0]        cfg_wdata,
  output logic [AW-1:0]        cfg_rdata,
  input  logic                 lk_valid,
  input  logic [AW-1:0]        lk_addr,
  input  logic                 lk_write,
  input  logic                 lk_user,
  output logic [AW-1:0]        lk_pa,
  output logic                 lk_hit,
  output logic                 lk_miss,
  output logic                 lk_fault,
  output logic                 lk_ci,
  output logic [AW-1:0]        fault_ea
);
  localparam int WB = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int SB = $clog2(SETS);
  localparam int VW = AW - OFF_W;

  logic [VW-1:0] vpn_q [WAYS][SETS];
  logic [VW-1:0] ppn_q [WAYS][SETS];
  logic [4:0]    prm_q [WAYS][SETS];
  logic          vld_q [WAYS][SETS];
  logic          lru_q [WAYS][SETS];

  logic [SB-1:0] idx;
  logic [VW-1:0] tag;
  logic          found;
  logic [WB-1:0] hw;
  logic [4:0]    p;
  logic          allowed, act, rd_ok;
  wire           unused_cfg = ^cfg_wdata[OFF_W-1:5];

  assign idx = lk_addr[OFF_W +: SB];
  assign tag = lk_addr[AW-1:OFF_W];
  assign act = lk_valid && xlat_en;

  always_comb begin
    found = 1'b0;
    hw    = '0;
    for (int w = WAYS-1; w >= 0; w--) begin
      if (vld_q[w][idx] && vpn_q[w][idx] == tag) begin
        found = 1'b1;
        hw    = WB'(w);
      end
    end
  end

  assign p       = prm_q[hw][idx];
  assign allowed = lk_user ? (lk_write ? p[4] : p[3]) : (lk_write ? p[2] : p[1]);
  assign lk_hit   = act && found;
  assign lk_miss  = act && !found;
  assign lk_fault = lk_hit && !allowed;
  assign lk_ci    = lk_hit && p[0];
  assign lk_pa    = lk_hit ? {ppn_q[hw][idx], lk_addr[OFF_W-1:0]} : lk_addr;

  assign rd_ok = int'(cfg_way) < WAYS;
  always_comb begin
    cfg_rdata = '0;
    if (rd_ok) begin
      if (cfg_word)
        cfg_rdata = {ppn_q[cfg_way][cfg_set], {(OFF_W-5){1'b0}}, prm_q[cfg_way][cfg_set]};
      else
        cfg_rdata = {vpn_q[cfg_way][cfg_set], {(OFF_W-2){1'b0}},
                     lru_q[cfg_way][cfg_set], vld_q[cfg_way][cfg_set]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_ea <= '0;
      for (int w = 0; w < WAYS; w++)
        for (int s = 0; s < SETS; s++) begin
          vpn_q[w][s] <= '0;
          ppn_q[w][s] <= '0;
          prm_q[w][s] <= '0;
          vld_q[w][s] <= 1'b0;
          lru_q[w][s] <= 1'b0;
        end
    end else begin
      if (lk_miss)
        fault_ea <= lk_addr;
      if (lk_hit)
        for (int w = 0; w < WAYS; w++)
          lru_q[w][idx] <= (WB'(w) == hw);
      if (cfg_wr && rd_ok) begin
        if (cfg_word) begin
          ppn_q[cfg_way][cfg_set] <= cfg_wdata[AW-1:OFF_W];
          prm_q[cfg_way][cfg_set] <= cfg_wdata[4:0];
        end else begin
          vpn_q[cfg_way][cfg_set] <= cfg_wdata[AW-1:OFF_W];
          lru_q[cfg_way][cfg_set] <= cfg_wdata[1];
          vld_q[cfg_way][cfg_set] <= cfg_wdata[0];
        end
      end
    end
  end

  a_r5_miss_capture: assert property (@(posedge clk) disable iff (!rst_n)
    lk_miss |=> fault_ea == $past(lk_addr));
  a_r3_hit_miss_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(lk_hit && lk_miss));
  a_r6_fault_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
    lk_fault |-> lk_hit);
  a_r8_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    !xlat_en |-> (lk_pa == lk_addr && !lk_miss && !lk_hit));
  a_r5_ea_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_miss |=> $stable(fault_ea));

  generate
    if (WAYS == 2) begin : g_pair
      logic [SB-1:0] lidx;
      assign lidx = lk_addr[OFF_W +: SB];
      a_r7_hint_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_hit && !cfg_wr) |=>
          $countones({lru_q[0][$past(lidx)], lru_q[1][$past(lidx)]}) == 1);
    end
  endgenerate
endmodule

// File: tb/sim_xlat_tlb.sv
module sim_xlat_tlb;
  logic        clk = 0, rst_n = 0, xlat_en = 0;
  logic        cfg_wr = 0, cfg_word = 0;
  logic [0:0]  cfg_way = '0;
  logic [3:0]  cfg_set = '0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic        lk_valid = 0, lk_write = 0, lk_user = 0;
  logic [31:0] lk_addr = '0, lk_pa, fault_ea;
  logic        lk_hit, lk_miss, lk_fault, lk_ci;

  int nchk = 0, nerr = 0;
  bit done = 0;
  logic [31:0] r_pa;
  logic        r_hit, r_miss, r_fault, r_ci;

  xlat_tlb u0 (.clk(clk), .rst_n(rst_n), .xlat_en(xlat_en), .cfg_wr(cfg_wr),
    .cfg_word(cfg_word), .cfg_way(cfg_way), .cfg_set(cfg_set), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_write(lk_write),
    .lk_user(lk_user), .lk_pa(lk_pa), .lk_hit(lk_hit), .lk_miss(lk_miss),
    .lk_fault(lk_fault), .lk_ci(lk_ci), .fault_ea(fault_ea));

  always #10 clk = ~clk;

  localparam logic [4:0] ALL = 5'b11110;

  function automatic logic [31:0] mw(input logic [19:0] v, input logic h, input logic ok);
    return {v, 10'b0, h, ok};
  endfunction
  function automatic logic [31:0] tw(input logic [19:0] pp, input logic [4:0] pr);
    return {pp, 7'b0, pr};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input bit word, input int way, input int set, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1; cfg_word = word; cfg_way = 1'(way); cfg_set = 4'(set); cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 0;
  endtask

  task automatic rd(input bit word, input int way, input int set, output logic [31:0] d);
    @(negedge clk);
    cfg_word = word; cfg_way = 1'(way); cfg_set = 4'(set);
    #2 d = cfg_rdata;
  endtask

  task automatic look(input logic [31:0] a, input bit w, input bit u);
    @(negedge clk);
    lk_valid = 1; lk_addr = a; lk_write = w; lk_user = u;
    #2;
    r_pa = lk_pa; r_hit = lk_hit; r_miss = lk_miss; r_fault = lk_fault; r_ci = lk_ci;
    @(negedge clk);
    lk_valid = 0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(0, 1, 3, d); chk("R11 match word", d, 0);
    rd(1, 0, 7, d); chk("R11 translate word", d, 0);
    chk("R11 fault_ea", fault_ea, 0);
    look(32'h0000_0000, 0, 0);
    chk("R11 miss after reset", {r_hit, r_miss}, 2'b01);
  endtask

  task automatic t_translate();
    logic [31:0] d;
    wr(0, 1, 5, mw(20'h40105, 0, 1));
    wr(1, 1, 5, tw(20'h80077, ALL));
    rd(0, 1, 5, d); chk("R9 match readback", d, 32'h4010_5001);
    rd(1, 1, 5, d); chk("R9 translate readback", d, 32'h8007_701E);
    look(32'h4010_5ABC, 0, 0);
    chk("R1 hit", {r_hit, r_miss, r_fault}, 3'b100);
    chk("R1 pa", r_pa, 32'h8007_7ABC);
    chk("R5 ea held over hit", fault_ea, 0);
  endtask

  task automatic t_tagbits();
    for (int b = 12; b < 32; b++) begin
      logic [31:0] a;
      a = 32'h4010_5ABC ^ (32'h1 << b);
      look(a, 0, 0);
      chk($sformatf("R3 flip bit %0d miss", b), {r_hit, r_miss}, 2'b01);
      chk($sformatf("R5 fault_ea bit %0d", b), fault_ea, a);
    end
  endtask

  task automatic t_index();
    wr(0, 0, 7, mw(20'h12346, 0, 1));
    wr(1, 0, 7, tw(20'h00001, ALL));
    look(32'h1234_6000, 0, 0);
    chk("R2 wrong set misses", {r_hit, r_miss}, 2'b01);
    wr(0, 0, 6, mw(20'h12346, 0, 1));
    wr(1, 0, 6, tw(20'h00002, ALL));
    look(32'h1234_6010, 0, 0);
    chk("R2 right set hits", r_pa, 32'h0000_2010);
  endtask

  task automatic t_valid();
    wr(0, 1, 5, mw(20'h40105, 0, 0));
    look(32'h4010_5ABC, 0, 0);
    chk("R4 invalid misses", {r_hit, r_miss}, 2'b01);
    chk("R4 fault_ea", fault_ea, 32'h4010_5ABC);
  endtask

  task automatic t_perm();
    wr(0, 0, 12, mw(20'h3333C, 0, 1));
    wr(1, 0, 12, tw(20'h0000C, 5'b01001));
    look(32'h3333_C004, 0, 1);
    chk("R6 user read ok", {r_hit, r_fault, r_ci}, 3'b101);
    look(32'h3333_C004, 1, 1);
    chk("R6 user write denied", {r_hit, r_fault}, 2'b11);
    look(32'h3333_C004, 0, 0);
    chk("R6 sup read denied", {r_hit, r_fault}, 2'b11);
    look(32'h3333_C004, 1, 0);
    chk("R6 sup write denied", {r_hit, r_fault}, 2'b11);
    wr(1, 0, 12, tw(20'h0000C, 5'b10100));
    look(32'h3333_C004, 1, 1);
    chk("R6 user write ok", {r_hit, r_fault, r_ci}, 3'b100);
    look(32'h3333_C004, 1, 0);
    chk("R6 sup write ok", {r_hit, r_fault}, 2'b10);
    look(32'h3333_C004, 0, 1);
    chk("R6 user read denied", {r_hit, r_fault}, 2'b11);
  endtask

  task automatic t_lru();
    logic [31:0] d0, d1;
    wr(0, 0, 9, mw(20'h00009, 0, 1)); wr(1, 0, 9, tw(20'h00100, ALL));
    wr(0, 1, 9, mw(20'h11119, 0, 1)); wr(1, 1, 9, tw(20'h00200, ALL));
    look(32'h0000_9000, 0, 0);
    rd(0, 0, 9, d0); rd(0, 1, 9, d1);
    chk("R7 hint after way0 hit", {d0[1], d1[1]}, 2'b10);
    look(32'h1111_9000, 0, 0);
    chk("R7 way1 pa", r_pa, 32'h0020_0000);
    rd(0, 0, 9, d0); rd(0, 1, 9, d1);
    chk("R7 hint after way1 hit", {d0[1], d1[1]}, 2'b01);
  endtask

  task automatic t_prio();
    wr(0, 0, 10, mw(20'h2222A, 0, 1)); wr(1, 0, 10, tw(20'h00AAA, ALL));
    wr(0, 1, 10, mw(20'h2222A, 0, 1)); wr(1, 1, 10, tw(20'h00BBB, ALL));
    look(32'h2222_A123, 0, 0);
    chk("R10 lower way wins", r_pa, 32'h00AA_A123);
    wr(0, 0, 10, mw(20'h2222A, 0, 0));
    look(32'h2222_A123, 0, 0);
    chk("R10 R9 upper way after invalidate", r_pa, 32'h00BB_B123);
  endtask

  task automatic t_disabled();
    logic [31:0] prev;
    prev = fault_ea;
    xlat_en = 0;
    look(32'hDEAD_BEEF, 1, 1);
    chk("R8 pa passthrough", r_pa, 32'hDEAD_BEEF);
    chk("R8 no flags", {r_hit, r_miss, r_fault}, 3'b000);
    chk("R8 R5 fault_ea held", fault_ea, prev);
    xlat_en = 1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    xlat_en = 1;
    t_reset();
    t_translate();
    t_tagbits();
    t_index();
    t_valid();
    t_perm();
    t_lru();
    t_prio();
    t_disabled();
    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      done = 1;
      nchk++; nerr++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule